// File: doc/BRIEF.md
# Conditional Hardware Store Arbiter

This block sits between a host, a small SRAM and a nonvolatile backing array. It owns the SRAM. It lets the host read and write while the system runs normally. It copies the whole SRAM into the nonvolatile array (a store), or rebuilds the SRAM from that array (a recall), when asked. A store can be requested on a shared active-low request/busy wire, which several such blocks pull low together. It can also be requested by a software strobe. A recall is requested by its own software strobe.

A request on the wire leads to a store only when the SRAM has been written since the last store or recall. Otherwise the block only holds off new writes until the wire returns high. While a store runs, the block pulls the wire low itself and turns away all host traffic. When the store ends it releases the wire. It then stays closed until it sees the wire high again, and reopens after a recovery count. A write that is already running when a request arrives gets a bounded grace window to finish. Reads keep working during that window.

Top module: `nvram_store_arbiter`

## Requirements
- R1: When `bus_line_i` goes low while no write has been committed since the last store or recall, no store is started (`nv_store_start_o` stays 0 and `busy_oe_o` stays 0).
- R2: A pulse on `sw_store_i` accepted in the idle state starts a full store even when the SRAM is clean.
- R3: `busy_oe_o` (1 = pull the shared wire low) rises within a few cycles of a store being committed. It stays 1 until `nv_done_i` is seen, and falls on the cycle after.
- R4: After a store ends, host reads give no `host_rvalid_o` and host writes are ignored until the synchronised wire is seen high. Access resumes `RECOVER_CYC` cycles later.
- R5: A write cycle running when a request arrives may finish within `GRACE_CYC` cycles and is then committed. If it runs longer it is dropped. Reads are served during the window.
- R6: A write cycle that starts (rising `host_wcyc_i`) while the synchronised wire is low, or while the block is not idle, is ignored.
- R7: A store streams every SRAM word to the nonvolatile array once, with `nv_we_o` high and `nv_addr_o` ascending from 0 to DEPTH-1.
- R8: A recall clears the SRAM, then loads every word from `nv_rdata_i` at `nv_raddr_o`. It never writes the nonvolatile array, and it can be repeated.
- R9: The dirty state is set by every committed write and cleared when a store or a recall completes.
- R10: After reset `busy_oe_o`, `host_rvalid_o`, `nv_we_o` and both start strobes are 0.
- R11: A software store and a wire request seen in the same idle cycle give exactly one store, which runs even if the SRAM is clean.
- R12: Software store or recall strobes that arrive outside the idle state are ignored.
- R13: A read accepted in cycle t gives `host_rvalid_o` in cycle t+1, with the word last committed at `host_raddr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_line_i | input | 1 | Sensed level of the shared active-low request/busy wire (asynchronous) |
| busy_oe_o | output | 1 | 1 = pull the shared wire low (open-drain enable) |
| sw_store_i | input | 1 | Software store strobe, one cycle |
| sw_recall_i | input | 1 | Software recall strobe, one cycle |
| host_rd_i | input | 1 | Host read request, one cycle |
| host_raddr_i | input | AW | Host read address |
| host_rdata_o | output | DW | Read data |
| host_rvalid_o | output | 1 | Read data valid |
| host_wcyc_i | input | 1 | Host write cycle, held high for the length of the write |
| host_waddr_i | input | AW | Host write address |
| host_wdata_i | input | DW | Host write data |
| nv_store_start_o | output | 1 | One-cycle strobe at the start of a store |
| nv_recall_start_o | output | 1 | One-cycle strobe as the recall load phase begins |
| nv_done_i | input | 1 | Nonvolatile array reports the store finished |
| nv_we_o | output | 1 | Store stream word valid |
| nv_addr_o | output | AW | Store stream address |
| nv_wdata_o | output | DW | Store stream data |
| nv_raddr_o | output | AW | Recall read address |
| nv_rdata_i | input | DW | Recall read data for `nv_raddr_o`, same cycle |

## Verification
A software store strobe and a wire request can reach the controller in the same idle cycle. The bench provokes this by pulling the wire and then raising the strobe exactly two cycles later, so both land together after synchronisation. The SRAM is clean at that point and the array has been seeded with unrelated data. The result is judged by exactly one store start and an array that afterwards matches the SRAM shadow. A second overlap is a running write against an incoming request: one write ends inside the grace window and must appear in the copy, and another outlasts it and must vanish.

// File: rtl/nsa_pkg.sv
package nsa_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GRACE,
    ST_HOLD,
    ST_COPY,
    ST_PROG,
    ST_WAITHI,
    ST_RECOV,
    ST_CLEAR,
    ST_LOAD
  } nsa_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_HW,
    OP_SW,
    OP_RCL
  } nsa_op_e;

endpackage

// File: rtl/nsa_sync.sv
module nsa_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nsa_sram.sv
module nsa_sram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/nsa_fsm.sv
module nsa_fsm
  import nsa_pkg::*;
#(
  parameter int AW          = 4,
  parameter int GRACE_CYC   = 16,
  parameter int RECOVER_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_hi,
  input  logic          sw_store,
  input  logic          sw_recall,
  input  logic          wr_live,
  input  logic          dirty,
  input  logic          nv_done,
  output nsa_state_e    st,
  output logic [AW-1:0] idx,
  output logic          busy_oe,
  output logic          nv_store_start,
  output logic          nv_recall_start,
  output logic          grace_abort,
  output logic          store_done,
  output logic          recall_done
);
  localparam int GW = $clog2(GRACE_CYC + 1);
  localparam int RW = $clog2(RECOVER_CYC + 1);
  localparam int CW = (GW > RW) ? GW : RW;
  localparam logic [AW-1:0] LAST  = '1;
  localparam logic [CW-1:0] G_LIM = CW'(GRACE_CYC);
  localparam logic [CW-1:0] R_LIM = CW'(RECOVER_CYC - 1);

  nsa_state_e    st_n;
  nsa_op_e       op, op_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [AW-1:0] idx_n;

  always_comb begin
    st_n  = st;
    op_n  = op;
    cnt_n = cnt;
    idx_n = idx;
    unique case (st)
      ST_IDLE: begin
        cnt_n = '0;
        if (sw_store) begin
          op_n = OP_SW;  st_n = ST_GRACE;
        end else if (sw_recall) begin
          op_n = OP_RCL; st_n = ST_GRACE;
        end else if (!line_hi) begin
          op_n = OP_HW;  st_n = ST_GRACE;
        end
      end
      ST_GRACE: begin
        if (!wr_live) begin
          idx_n = '0;
          unique case (op)
            OP_RCL:  st_n = ST_CLEAR;
            OP_SW:   st_n = ST_COPY;
            default: st_n = dirty ? ST_COPY : ST_HOLD;
          endcase
        end else if (cnt != G_LIM) begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_HOLD: begin
        if (line_hi) st_n = ST_IDLE;
      end
      ST_COPY: begin
        if (idx == LAST) st_n = ST_PROG;
        else             idx_n = idx + 1'b1;
      end
      ST_PROG: begin
        if (nv_done) st_n = ST_WAITHI;
      end
      ST_WAITHI: begin
        cnt_n = '0;
        if (line_hi) st_n = ST_RECOV;
      end
      ST_RECOV: begin
        if (cnt == R_LIM) st_n = ST_IDLE;
        else              cnt_n = cnt + 1'b1;
      end
      ST_CLEAR: begin
        if (idx == LAST) begin
          st_n = ST_LOAD; idx_n = '0;
        end else begin
          idx_n = idx + 1'b1;
        end
      end
      ST_LOAD: begin
        if (idx == LAST) st_n = ST_IDLE;
        else             idx_n = idx + 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st              <= ST_IDLE;
      op              <= OP_NONE;
      cnt             <= '0;
      idx             <= '0;
      busy_oe         <= 1'b0;
      nv_store_start  <= 1'b0;
      nv_recall_start <= 1'b0;
    end else begin
      st              <= st_n;
      op              <= op_n;
      cnt             <= cnt_n;
      idx             <= idx_n;
      busy_oe         <= (st_n == ST_COPY) || (st_n == ST_PROG);
      nv_store_start  <= (st_n == ST_COPY) && (st != ST_COPY);
      nv_recall_start <= (st_n == ST_LOAD) && (st != ST_LOAD);
    end
  end

  assign grace_abort = (st == ST_GRACE) && wr_live && (cnt == G_LIM);
  assign store_done  = (st == ST_PROG) && nv_done;
  assign recall_done = (st == ST_LOAD) && (idx == LAST);

  // R1: a wire request on a clean SRAM parks in HOLD without driving the wire
  p_clean_skip_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GRACE && op == OP_HW && !wr_live && !dirty) |=> (st == ST_HOLD && !busy_oe));

  // R2: a software store proceeds to the copy regardless of dirty
  p_sw_store_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GRACE && op == OP_SW && !wr_live) |=> (st == ST_COPY && busy_oe));

  // R3: the wire stays pulled while the array has not reported completion
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && !nv_done) |=> busy_oe);

  // R4: the wire is released while waiting for it to return high
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAITHI) |-> !busy_oe);

  // R5: the grace counter never passes its limit
  p_grace_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GRACE) |-> (cnt <= G_LIM));
endmodule

// File: rtl/nvram_store_arbiter.sv
module nvram_store_arbiter
  import nsa_pkg::*;
#(
  parameter int AW          = 4,
  parameter int DW          = 8,
  parameter int GRACE_CYC   = 16,
  parameter int RECOVER_CYC = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_line_i,
  output logic          busy_oe_o,
  input  logic          sw_store_i,
  input  logic          sw_recall_i,
  input  logic          host_rd_i,
  input  logic [AW-1:0] host_raddr_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          host_rvalid_o,
  input  logic          host_wcyc_i,
  input  logic [AW-1:0] host_waddr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic          nv_store_start_o,
  output logic          nv_recall_start_o,
  input  logic          nv_done_i,
  output logic          nv_we_o,
  output logic [AW-1:0] nv_addr_o,
  output logic [DW-1:0] nv_wdata_o,
  output logic [AW-1:0] nv_raddr_o,
  input  logic [DW-1:0] nv_rdata_i
);
  nsa_state_e    st;
  logic [AW-1:0] idx;
  logic          line_hi;
  logic          grace_abort, store_done, recall_done;
  logic          wcyc_q, wr_live, wr_acc, commit, dirty;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;
  logic          rd_ok, mem_re, mem_we;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          copy_v;
  logic [AW-1:0] copy_a;

  nsa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_line_i),
    .q   (line_hi)
  );

  nsa_fsm #(.AW(AW), .GRACE_CYC(GRACE_CYC), .RECOVER_CYC(RECOVER_CYC)) u_fsm (
    .clk             (clk),
    .rst             (rst),
    .line_hi         (line_hi),
    .sw_store        (sw_store_i),
    .sw_recall       (sw_recall_i),
    .wr_live         (wr_live),
    .dirty           (dirty),
    .nv_done         (nv_done_i),
    .st              (st),
    .idx             (idx),
    .busy_oe         (busy_oe_o),
    .nv_store_start  (nv_store_start_o),
    .nv_recall_start (nv_recall_start_o),
    .grace_abort     (grace_abort),
    .store_done      (store_done),
    .recall_done     (recall_done)
  );

  // host write cycle: accepted on its rising edge, committed on its falling edge
  assign wr_acc = host_wcyc_i && !wcyc_q && (st == ST_IDLE) && line_hi
                  && !sw_store_i && !sw_recall_i;
  assign commit = wr_live && !host_wcyc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcyc_q  <= 1'b0;
      wr_live <= 1'b0;
      wa      <= '0;
      wd      <= '0;
    end else begin
      wcyc_q <= host_wcyc_i;
      if (wr_acc)           wr_live <= 1'b1;
      else if (commit)      wr_live <= 1'b0;
      else if (grace_abort) wr_live <= 1'b0;
      if (host_wcyc_i && (wr_acc || wr_live)) begin
        wa <= host_waddr_i;
        wd <= host_wdata_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            dirty <= 1'b0;
    else if (commit)                    dirty <= 1'b1;
    else if (store_done || recall_done) dirty <= 1'b0;
  end

  // memory port muxing
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = idx;
    mem_wdata = '0;
    if (commit) begin
      mem_we    = 1'b1;
      mem_waddr = wa;
      mem_wdata = wd;
    end else if (st == ST_CLEAR) begin
      mem_we    = 1'b1;
    end else if (st == ST_LOAD) begin
      mem_we    = 1'b1;
      mem_wdata = nv_rdata_i;
    end
  end

  assign rd_ok     = host_rd_i && (st == ST_IDLE || st == ST_GRACE || st == ST_HOLD);
  assign mem_re    = rd_ok || (st == ST_COPY);
  assign mem_raddr = (st == ST_COPY) ? idx : host_raddr_i;

  nsa_sram #(.AW(AW), .DW(DW)) u_sram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid_o <= 1'b0;
      copy_v        <= 1'b0;
      copy_a        <= '0;
    end else begin
      host_rvalid_o <= rd_ok;
      copy_v        <= (st == ST_COPY);
      copy_a        <= idx;
    end
  end

  assign host_rdata_o = mem_rdata;
  assign nv_we_o      = copy_v;
  assign nv_addr_o    = copy_a;
  assign nv_wdata_o   = mem_rdata;
  assign nv_raddr_o   = idx;

  // R6: a write only becomes live after a cycle in which the wire was high
  p_wr_start_hi_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_live) |-> $past(line_hi));

  // R4: no write lands while a store is running or the block is closed
  p_no_commit_closed_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COPY || st == ST_PROG || st == ST_WAITHI || st == ST_RECOV) |-> !commit);

  // R9: a committed write leaves the block dirty
  p_dirty_set_r9: assert property (@(posedge clk) disable iff (rst)
    commit |=> dirty);

  // R13: read data is only flagged for an accepted read
  p_rvalid_r13: assert property (@(posedge clk) disable iff (rst)
    host_rvalid_o |-> $past(host_rd_i));
endmodule

// File: tb/nvram_store_arbiter_tb.sv
module nvram_store_arbiter_tb_top;
  localparam int AW = 4, DW = 8, DEPTH = 16, GRACE = 16, RECOV = 4, NV_LAT = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, ext_pull, sw_store, sw_recall, host_rd, host_wcyc, nv_done;
  logic [AW-1:0] host_raddr, host_waddr, nv_addr, nv_raddr;
  logic [DW-1:0] host_wdata, host_rdata, nv_wdata, nv_rdata;
  logic busy_oe, host_rvalid, nv_store_start, nv_recall_start, nv_we;
  logic bus_line;

  assign bus_line = !(busy_oe || ext_pull);

  nvram_store_arbiter #(.AW(AW), .DW(DW), .GRACE_CYC(GRACE), .RECOVER_CYC(RECOV)) dut_i (
    .clk(clk), .rst(rst), .bus_line_i(bus_line), .busy_oe_o(busy_oe),
    .sw_store_i(sw_store), .sw_recall_i(sw_recall),
    .host_rd_i(host_rd), .host_raddr_i(host_raddr), .host_rdata_o(host_rdata),
    .host_rvalid_o(host_rvalid), .host_wcyc_i(host_wcyc), .host_waddr_i(host_waddr),
    .host_wdata_i(host_wdata), .nv_store_start_o(nv_store_start),
    .nv_recall_start_o(nv_recall_start), .nv_done_i(nv_done), .nv_we_o(nv_we),
    .nv_addr_o(nv_addr), .nv_wdata_o(nv_wdata), .nv_raddr_o(nv_raddr), .nv_rdata_i(nv_rdata)
  );

  // nonvolatile array model and stream monitor
  logic [DW-1:0] nv_mem  [DEPTH];
  logic [DW-1:0] nv_seed [DEPTH];
  logic [DW-1:0] sram_exp[DEPTH];
  logic          preload;
  int n_store, n_recall, stream_bad, early_drop, done_cnt;
  logic [AW:0] exp_next;
  logic done_seen, busy_q;

  assign nv_rdata = nv_mem[nv_raddr];

  always @(posedge clk) begin
    if (rst) begin
      n_store <= 0; n_recall <= 0; stream_bad <= 0; early_drop <= 0;
      done_cnt <= 0; nv_done <= 1'b0; exp_next <= '0; done_seen <= 1'b0; busy_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) nv_mem[i] <= '0;
    end else begin
      if (preload) for (int i = 0; i < DEPTH; i++) nv_mem[i] <= nv_seed[i];
      if (nv_we) begin
        nv_mem[nv_addr] <= nv_wdata;
        if ({1'b0, nv_addr} != exp_next) stream_bad <= stream_bad + 1;
        exp_next <= exp_next + 1'b1;
      end
      if (nv_store_start) begin
        n_store <= n_store + 1; exp_next <= '0; done_cnt <= NV_LAT; done_seen <= 1'b0;
        nv_done <= 1'b0;
      end else begin
        if (done_cnt != 0) done_cnt <= done_cnt - 1;
        nv_done <= (done_cnt == 1);
        if (nv_done) done_seen <= 1'b1;
      end
      if (nv_recall_start) n_recall <= n_recall + 1;
      if (busy_q && !busy_oe && !done_seen) early_drop <= early_drop + 1;
      busy_q <= busy_oe;
    end
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
    @(negedge clk);
    host_wcyc = 1'b1; host_waddr = a; host_wdata = d;
    repeat (len) @(negedge clk);
    host_wcyc = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    host_rd = 1'b1; host_raddr = a;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rvalid; d = host_rdata;
  endtask

  task automatic pulse_store();
    @(negedge clk); sw_store = 1'b1;
    @(negedge clk); sw_store = 1'b0;
  endtask

  task automatic pulse_recall();
    @(negedge clk); sw_recall = 1'b1;
    @(negedge clk); sw_recall = 1'b0;
  endtask

  task automatic wait_busy(input logic lvl, input int lim, input string tag, output int took);
    took = 0;
    while (busy_oe !== lvl && took < lim) begin
      @(negedge clk); took++;
    end
    chk(busy_oe === lvl, tag, {31'b0, busy_oe}, {31'b0, lvl});
  endtask

  task automatic cmp_sram(input string tag);
    logic [DW-1:0] d; logic v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), d, v);
      chk(v && d == sram_exp[i], tag, {23'b0, v, d}, {23'b0, 1'b1, sram_exp[i]});
    end
  endtask

  task automatic cmp_nv(input string tag);
    for (int i = 0; i < DEPTH; i++)
      chk(nv_mem[i] == sram_exp[i], tag, nv_mem[i], sram_exp[i]);
  endtask

  task automatic seed_nv(output logic [DW-1:0] s[DEPTH]);
    for (int i = 0; i < DEPTH; i++) begin
      nv_seed[i] = DW'($urandom);
      s[i] = nv_seed[i];
    end
    @(negedge clk); preload = 1'b1;
    @(negedge clk); preload = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int t, n0, r0;
    logic [DW-1:0] d, keep;
    logic v;
    logic [DW-1:0] s[DEPTH];
    void'($urandom(32'h0051_7e5d));
    rst = 1'b1; ext_pull = 0; sw_store = 0; sw_recall = 0; host_rd = 0; host_wcyc = 0;
    host_raddr = '0; host_waddr = '0; host_wdata = '0; preload = 0;
    for (int i = 0; i < DEPTH; i++) nv_seed[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!busy_oe && !host_rvalid && !nv_we && !nv_store_start && !nv_recall_start,
        "R10 reset outputs", {27'b0, busy_oe, host_rvalid, nv_we, nv_store_start, nv_recall_start}, 0);

    // R13 random fill then read back
    for (int i = 0; i < DEPTH; i++) begin
      d = DW'($urandom);
      wr(AW'(i), d, 1 + int'($urandom % 3));
      sram_exp[i] = d;
    end
    cmp_sram("R13 read back");

    // R3 R4 R7 wire-requested store on a dirty SRAM
    n0 = n_store;
    @(negedge clk); ext_pull = 1'b1;
    wait_busy(1'b1, 12, "R3 busy asserts", t);
    chk(t <= 6, "R3 busy latency", t, 6);
    rd(4'd3, d, v);
    chk(!v, "R4 read refused during store", v, 0);
    wait_busy(1'b0, 200, "R3 busy release", t);
    chk(early_drop == 0, "R3 busy held until done", early_drop, 0);
    chk(n_store == n0 + 1, "R3 one store", n_store, n0 + 1);
    repeat (10) @(negedge clk);
    rd(4'd5, d, v);
    chk(!v, "R4 read refused while wire low", v, 0);
    wr(4'd5, ~sram_exp[5], 1);
    ext_pull = 1'b0;
    repeat (RECOV + 8) @(negedge clk);
    rd(4'd5, d, v);
    chk(v && d == sram_exp[5], "R4 access resumes, write ignored", {23'b0, v, d}, {24'h1, sram_exp[5]});
    cmp_nv("R7 stored image");
    chk(stream_bad == 0, "R7 ascending stream", stream_bad, 0);

    // R1 R6 wire request on a clean SRAM
    n0 = n_store;
    @(negedge clk); ext_pull = 1'b1;
    repeat (12) @(negedge clk);
    chk(n_store == n0 && !busy_oe, "R1 no store when clean", n_store, n0);
    rd(4'd2, d, v);
    chk(v && d == sram_exp[2], "R1 reads served while held", {23'b0, v, d}, {24'h1, sram_exp[2]});
    keep = sram_exp[7];
    wr(4'd7, ~keep, 2);
    ext_pull = 1'b0;
    repeat (8) @(negedge clk);
    rd(4'd7, d, v);
    chk(v && d == keep, "R6 write during low ignored", d, keep);
    d = DW'($urandom); wr(4'd7, d, 1); sram_exp[7] = d;
    rd(4'd7, d, v);
    chk(v && d == sram_exp[7], "R6 write accepted after high", d, sram_exp[7]);

    // R2 software store: first while dirty, then while clean over a seeded array
    pulse_store();
    wait_busy(1'b1, 12, "R2 busy rises", t);
    wait_busy(1'b0, 200, "R2 busy falls", t);
    repeat (10) @(negedge clk);
    seed_nv(s);
    n0 = n_store;
    pulse_store();
    wait_busy(1'b1, 12, "R2 clean store busy", t);
    wait_busy(1'b0, 200, "R2 clean store ends", t);
    repeat (10) @(negedge clk);
    chk(n_store == n0 + 1, "R2 store while clean", n_store, n0 + 1);
    cmp_nv("R2 clean store image");

    // R5 write outlasting the grace window is dropped, reads served meanwhile
    n0 = n_store; keep = sram_exp[9];
    fork
      wr(4'd9, ~keep, GRACE + 20);
      begin
        repeat (3) @(negedge clk); ext_pull = 1'b1;
        repeat (8) @(negedge clk);
        rd(4'd2, d, v);
        chk(v && d == sram_exp[2], "R5 read during grace", {23'b0, v, d}, {24'h1, sram_exp[2]});
      end
    join
    repeat (4) @(negedge clk);
    chk(n_store == n0, "R5 dropped write leaves clean", n_store, n0);
    ext_pull = 1'b0;
    repeat (8) @(negedge clk);
    rd(4'd9, d, v);
    chk(v && d == keep, "R5 overlong write dropped", d, keep);

    // R5 write ending inside the window is committed and stored
    n0 = n_store; d = DW'($urandom);
    fork
      wr(4'd10, d, 10);
      begin repeat (2) @(negedge clk); ext_pull = 1'b1; end
    join
    sram_exp[10] = d;
    wait_busy(1'b1, 20, "R5 store after grace", t);
    wait_busy(1'b0, 200, "R5 store ends", t);
    chk(n_store == n0 + 1 && nv_mem[10] == d, "R5 graced write stored", nv_mem[10], d);
    ext_pull = 1'b0;
    repeat (RECOV + 8) @(negedge clk);

    // R11 software strobe and wire request in the same cycle, SRAM clean
    seed_nv(s);
    n0 = n_store;
    @(negedge clk); ext_pull = 1'b1;
    @(negedge clk);
    @(negedge clk); sw_store = 1'b1;
    @(negedge clk); sw_store = 1'b0;
    wait_busy(1'b1, 12, "R11 busy", t);
    wait_busy(1'b0, 200, "R11 done", t);
    repeat (10) @(negedge clk);
    chk(n_store == n0 + 1, "R11 exactly one store", n_store, n0 + 1);
    cmp_nv("R11 image");
    ext_pull = 1'b0;
    repeat (RECOV + 8) @(negedge clk);

    // R12 recall strobe during a store is ignored
    r0 = n_recall;
    pulse_store();
    wait_busy(1'b1, 12, "R12 busy", t);
    pulse_recall();
    wait_busy(1'b0, 200, "R12 done", t);
    repeat (2 * DEPTH + 10) @(negedge clk);
    chk(n_recall == r0, "R12 recall ignored", n_recall, r0);

    // R8 recall twice, R9 clean afterwards
    for (int k = 0; k < 2; k++) begin
      seed_nv(s);
      if (k == 1) begin
        wr(4'd0, ~s[0], 1);
        wr(4'd15, ~s[15], 2);
      end
      r0 = n_recall;
      pulse_recall();
      repeat (2 * DEPTH + 10) @(negedge clk);
      chk(n_recall == r0 + 1, "R8 recall started", n_recall, r0 + 1);
      for (int i = 0; i < DEPTH; i++) sram_exp[i] = s[i];
      cmp_sram("R8 recalled data");
      for (int i = 0; i < DEPTH; i++)
        chk(nv_mem[i] == s[i], "R8 array unchanged", nv_mem[i], s[i]);
    end
    n0 = n_store;
    @(negedge clk); ext_pull = 1'b1;
    repeat (12) @(negedge clk);
    chk(n_store == n0 && !busy_oe, "R9 recall cleared dirty", n_store, n0);
    ext_pull = 1'b0;
    repeat (8) @(negedge clk);

    finish_up();
  end
endmodule